// File: doc/BRIEF.md
# ADC Parallel Byte-Wide Result Reader

This block sits on the host side of a 16-bit successive-approximation converter whose result is read over an 8-bit three-state bus. It issues a short convert strobe by holding read/convert low together with chip select low, then waits for the converter's busy line to fall and rise again. It then enables the bus with read/convert high and chip select low. It reads the upper byte with byte select low and the lower byte with byte select high, and gives each bus state the full access time before sampling.

After both bytes are captured, chip select is released and the assembled word is presented with a one-cycle valid strobe. The bus then gets a relinquish interval before anything else happens on it. All delays are counted in system clock cycles derived from nanosecond parameters and the clock frequency, rounded up. Conversions are started by a single-cycle request or by a free-running mode. In both cases a throughput pacer enforces a minimum spacing between convert strobes.

Top module: `adc_byte_reader`

## Requirements
- R1: While and right after reset, rd_conv_o is high, cs_no is high, byte_sel_o is low and word_valid_o is low.
- R2: A conversion is started by driving rd_conv_o low for exactly CONV_CYC cycles (CONV_NS rounded up to whole clock cycles, at least one), with cs_no low for that whole time. rd_conv_o is never low while cs_no is high.
- R3: After each conversion the block reads the upper byte (result bits 15:8) with byte_sel_o low, then the lower byte (bits 7:0) with byte_sel_o high. word_o is {upper, lower}. byte_sel_o is high only while cs_no is low and rd_conv_o is high.
- R4: Each byte is sampled only after the bus has been enabled, or byte_sel_o has changed, for ACC_CYC full cycles (ACCESS_NS rounded up).
- R5: The bus is enabled only after busy_i, seen through a two-flop synchronizer, has been low and then high following the block's own convert strobe. A busy_i level that is still high right after the strobe does not count.
- R6: word_valid_o is high for exactly one cycle per read, in the first cycle with cs_no high again. word_o keeps its value until the next strobe.
- R7: After cs_no rises at the end of a read, no new convert strobe begins for at least REL_CYC cycles (RELEASE_NS rounded up).
- R8: The starts of two convert strobes are at least PER_CYC cycles apart (PERIOD_NS rounded up).
- R9: While free_run_i is high, and each read ends in time, convert strobes start exactly PER_CYC cycles apart.
- R10: A start_i pulse that arrives while the block is busy or paced is held and served once. Several such pulses collapse into one conversion. start_i and free_run_i asserted in the same cycle produce a single conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single conversion request, one cycle |
| free_run_i | input | 1 | Level: convert continuously at the paced rate |
| busy_i | input | 1 | Converter busy line, low while converting |
| data_i | input | 8 | Converter byte bus |
| rd_conv_o | output | 1 | Read/convert control, low = convert |
| cs_no | output | 1 | Converter chip select, active low |
| byte_sel_o | output | 1 | Byte select, low = upper byte |
| word_o | output | 16 | Last assembled result |
| word_valid_o | output | 1 | One-cycle strobe marking a new word_o |

## Verification
Two functions can land in the same cycle: a held start_i request and a free-run trigger, or a fresh start_i and free_run_i together. The bench raises both in one cycle while the pacer is ready, and counts convert strobes over a long window, expecting exactly one. It also stacks several start_i pulses during a running conversion and expects exactly one extra strobe. A converter model delays busy, varies conversion length and shows corrupted bytes until the access time has passed, so a read that starts early or samples early shows up as a wrong word.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_RD_HI,
    ST_RD_LO,
    ST_REL
  } rd_state_e;

  // ceil(ns * hz / 1e9), never below one cycle
  function automatic int unsigned ns_to_cyc(longint unsigned ns, longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    return (c == 0) ? 1 : int'(c);
  endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  // reset high: converter idles with busy high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  p_timer_rest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));

  p_timer_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/adc_rd_pacer.sv
module adc_rd_pacer #(
  parameter int PER_CYC = 1250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  output logic ready_o
);
  localparam int PW = (PER_CYC > 1) ? $clog2(PER_CYC) : 1;
  localparam logic [PW-1:0] TOP = PW'(PER_CYC - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= TOP;
    else if (launch_i)      cnt_q <= '0;
    else if (cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == TOP);

  p_launch_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> ready_o);

  p_launch_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> (cnt_q == '0));
endmodule

// File: rtl/adc_byte_reader.sv
module adc_byte_reader #(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned CONV_NS    = 40,
  parameter int unsigned ACCESS_NS  = 83,
  parameter int unsigned RELEASE_NS = 83,
  parameter int unsigned PERIOD_NS  = 25_000,
  parameter int          BYTE_W     = 8,
  parameter int          SYNC_STG   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                free_run_i,
  input  logic                busy_i,
  input  logic [BYTE_W-1:0]   data_i,
  output logic                rd_conv_o,
  output logic                cs_no,
  output logic                byte_sel_o,
  output logic [2*BYTE_W-1:0] word_o,
  output logic                word_valid_o
);
  import adc_rd_pkg::*;

  localparam int CONV_CYC = int'(ns_to_cyc(CONV_NS, CLK_HZ));
  localparam int ACC_CYC  = int'(ns_to_cyc(ACCESS_NS, CLK_HZ));
  localparam int REL_CYC  = int'(ns_to_cyc(RELEASE_NS, CLK_HZ));
  localparam int PER_CYC  = int'(ns_to_cyc(PERIOD_NS, CLK_HZ));
  localparam int MAX_A    = (CONV_CYC > ACC_CYC) ? CONV_CYC : ACC_CYC;
  localparam int MAX_CYC  = (MAX_A > REL_CYC) ? MAX_A : REL_CYC;
  localparam int TW       = $clog2(MAX_CYC + 1);

  rd_state_e state_q, state_d;
  logic busy_s, pace_ready, launch, req_q;
  logic tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic rc_d, cs_d, sel_d;
  logic [BYTE_W-1:0] hi_q;

  adc_rd_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (busy_i),
    .q_o   (busy_s)
  );

  adc_rd_pacer #(.PER_CYC(PER_CYC)) u_pacer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .ready_o (pace_ready)
  );

  adc_rd_timer #(.W(TW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .done_o(tmr_done)
  );

  assign launch = (state_q == ST_IDLE) && pace_ready && (req_q || start_i || free_run_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (launch)   state_d = ST_CONV;
      ST_CONV:    if (tmr_done) state_d = ST_WAIT_LO;
      ST_WAIT_LO: if (!busy_s)  state_d = ST_WAIT_HI;
      ST_WAIT_HI: if (busy_s)   state_d = ST_RD_HI;
      ST_RD_HI:   if (tmr_done) state_d = ST_RD_LO;
      ST_RD_LO:   if (tmr_done) state_d = ST_REL;
      ST_REL:     if (tmr_done) state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  // timer reloads on entry to every timed state (byte change counts as entry)
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state_d != state_q) begin
      unique case (state_d)
        ST_CONV:  begin tmr_load = 1'b1; tmr_val = TW'(CONV_CYC - 1); end
        ST_RD_HI,
        ST_RD_LO: begin tmr_load = 1'b1; tmr_val = TW'(ACC_CYC - 1);  end
        ST_REL:   begin tmr_load = 1'b1; tmr_val = TW'(REL_CYC - 1);  end
        default:  ;
      endcase
    end
  end

  // pin levels decoded from next state so they switch with the state register
  always_comb begin
    rc_d  = 1'b1;
    cs_d  = 1'b1;
    sel_d = 1'b0;
    unique case (state_d)
      ST_CONV:  begin rc_d = 1'b0; cs_d = 1'b0; end
      ST_RD_HI: cs_d = 1'b0;
      ST_RD_LO: begin cs_d = 1'b0; sel_d = 1'b1; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      req_q      <= 1'b0;
      rd_conv_o  <= 1'b1;
      cs_no      <= 1'b1;
      byte_sel_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      req_q      <= (req_q | start_i) & ~launch;
      rd_conv_o  <= rc_d;
      cs_no      <= cs_d;
      byte_sel_o <= sel_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q         <= '0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= 1'b0;
      if (state_q == ST_RD_HI && tmr_done) hi_q <= data_i;
      if (state_q == ST_RD_LO && tmr_done) begin
        word_o       <= {hi_q, data_i};
        word_valid_o <= 1'b1;
      end
    end
  end

  p_rc_needs_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_conv_o |-> !cs_no);

  p_sel_in_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_sel_o |-> (!cs_no && rd_conv_o));

  p_enable_after_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_no) && rd_conv_o) |-> busy_s);

  p_valid_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  p_valid_at_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (cs_no && $past(!cs_no)));

  p_word_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_o |-> $stable(word_o));
endmodule

// File: tb/adc_byte_reader_tb_top.sv
module adc_byte_reader_tb_top;
  localparam int CLK_HZ = 50_000_000;
  localparam int CONV_NS = 40, ACC_NS = 83, REL_NS = 83, PER_NS = 2000;

  function automatic int ns2cyc(int ns);
    longint c;
    c = (longint'(ns) * CLK_HZ + 64'd999_999_999) / 64'd1_000_000_000;
    return (c == 0) ? 1 : int'(c);
  endfunction

  localparam int CONV_C = ns2cyc(CONV_NS);
  localparam int ACC_C  = ns2cyc(ACC_NS);
  localparam int REL_C  = ns2cyc(REL_NS);
  localparam int PER_C  = ns2cyc(PER_NS);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, fr = 1'b0;
  logic busy_m;
  logic [7:0] bus;
  logic rc, cs_n, sel, wvalid;
  logic [15:0] word;

  always #10 clk = ~clk;

  adc_byte_reader #(
    .CLK_HZ(CLK_HZ), .CONV_NS(CONV_NS), .ACCESS_NS(ACC_NS),
    .RELEASE_NS(REL_NS), .PERIOD_NS(PER_NS)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .free_run_i(fr),
    .busy_i(busy_m), .data_i(bus), .rd_conv_o(rc), .cs_no(cs_n),
    .byte_sel_o(sel), .word_o(word), .word_valid_o(wvalid)
  );

  int n_chk = 0, n_err = 0;
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // converter model
  int lo_dly = 3, conv_len = 40, cur_lo, cur_len, ph;
  logic conv_act = 1'b0, fresh = 1'b0;
  logic [15:0] word_m = 16'h0, next_word = 16'h1234;
  int stable = 0;
  logic prev_en = 1'b0, prev_sel = 1'b0;
  logic bus_en;
  logic [7:0] bus_sel;

  always @(posedge clk) begin
    if (!rst_n) begin
      busy_m <= 1'b1; conv_act <= 1'b0; fresh <= 1'b0;
    end else if (!conv_act) begin
      if (!cs_n && !rc) begin
        conv_act <= 1'b1; ph <= 0; fresh <= 1'b0;
        cur_lo <= lo_dly; cur_len <= conv_len;
      end
    end else begin
      ph <= ph + 1;
      if (ph == cur_lo) busy_m <= 1'b0;
      if (ph == cur_lo + cur_len) begin
        busy_m <= 1'b1; word_m <= next_word; next_word <= 16'($urandom);
        conv_act <= 1'b0; fresh <= 1'b1;
      end
    end
  end

  initial busy_m = 1'b1;

  // bus: corrupted until ACC_C-1 edges after enable or byte change
  always @(posedge clk) begin
    if (bus_en && prev_en && sel == prev_sel) stable <= stable + 1;
    else stable <= 0;
    prev_en <= bus_en; prev_sel <= sel;
  end
  assign bus_en  = !cs_n && rc;
  assign bus_sel = sel ? word_m[7:0] : word_m[15:8];
  assign bus     = (bus_en && stable >= ACC_C - 2) ? bus_sel : ~bus_sel;

  // monitor
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_start = 0, n_valid = 0, last_start = -1, last_rel = -1, plen = 0;
  logic exact_mode = 1'b0, last_exact = 1'b0;
  logic p_rc = 1'b1, p_cs = 1'b1, p_valid = 1'b0;
  logic [15:0] p_word = 16'h0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!rc) begin
        plen++;
        chk(!cs_n, "R2", "cs low during convert", cs_n, 0);
      end
      if (!rc && p_rc) begin
        n_start++;
        if (last_start >= 0)
          chk(cyc - last_start >= PER_C, "R8", "start spacing", cyc - last_start, PER_C);
        if (exact_mode && last_exact && last_start >= 0)
          chk(cyc - last_start == PER_C, "R9", "free-run spacing", cyc - last_start, PER_C);
        if (last_rel >= 0)
          chk(cyc - last_rel >= REL_C, "R7", "release gap", cyc - last_rel, REL_C);
        last_start = cyc; last_exact = exact_mode;
      end
      if (rc && !p_rc) begin
        chk(plen == CONV_C, "R2", "convert pulse length", plen, CONV_C);
        plen = 0;
      end
      if (!cs_n && p_cs && rc)
        chk(fresh && busy_m && !conv_act, "R5", "bus enabled after busy cycle", fresh, 1);
      if (cs_n && !p_cs) last_rel = cyc;
      if (sel) chk(!cs_n && rc, "R3", "byte select outside read", cs_n, 0);
      if (wvalid) begin
        n_valid++;
        chk(word == word_m, "R3", "word value (R4 access)", word, word_m);
        chk(cs_n && !p_cs, "R6", "valid at release", cs_n, 1);
      end
      if (p_valid) begin
        chk(!wvalid, "R6", "valid width", wvalid, 0);
        chk(word == p_word, "R6", "word hold", word, p_word);
      end
    end
    p_rc = rc; p_cs = cs_n; p_valid = wvalid; p_word = word;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150_000);
    chk(0, "watchdog", "run did not end", cyc, 0);
    report();
  end

  initial begin
    int s0;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk(rc == 1'b1, "R1", "rd_conv reset", rc, 1);
    chk(cs_n == 1'b1, "R1", "cs reset", cs_n, 1);
    chk(sel == 1'b0, "R1", "byte select reset", sel, 0);
    chk(wvalid == 1'b0, "R1", "valid reset", wvalid, 0);
    rst_n = 1'b1;
    idle(2);
    chk(rc && cs_n && !wvalid, "R1", "idle after reset", {rc, cs_n, wvalid}, 3'b110);

    // single shot
    pulse_start();
    idle(200);
    chk(n_valid == 1, "R3", "first read done", n_valid, 1);

    // busy stays high long after strobe
    lo_dly = 30;
    pulse_start();
    idle(250);
    lo_dly = 3;
    chk(n_valid == 2, "R5", "late busy read", n_valid, 2);

    // free-running
    s0 = n_start;
    exact_mode = 1'b1; fr = 1'b1;
    idle(PER_C * 5 + 20);
    fr = 1'b0; exact_mode = 1'b0;
    idle(300);
    chk(n_start - s0 == 6, "R9", "free-run count", n_start - s0, 6);

    // held requests collapse
    s0 = n_start;
    pulse_start();
    idle(20);
    pulse_start();
    idle(5);
    pulse_start();
    idle(400);
    chk(n_start - s0 == 2, "R10", "pending collapse", n_start - s0, 2);

    // start and free-run in the same cycle
    s0 = n_start;
    @(negedge clk) begin start = 1'b1; fr = 1'b1; end
    @(negedge clk) begin start = 1'b0; fr = 1'b0; end
    idle(400);
    chk(n_start - s0 == 1, "R10", "same-cycle single conversion", n_start - s0, 1);

    // random traffic
    for (int i = 0; i < 40; i++) begin
      while (conv_act) @(negedge clk);
      conv_len = 20 + int'($urandom % 140);
      lo_dly   = 2 + int'($urandom % 6);
      if ($urandom % 4 == 0) begin
        fr = 1'b1; idle(1 + int'($urandom % 3)); fr = 1'b0;
      end else begin
        pulse_start();
      end
      idle(int'($urandom % 150));
    end
    idle(600);
    chk(n_valid == n_start, "R3", "every conversion read", n_valid, n_start);
    report();
  end
endmodule